// File: doc/BRIEF.md
# ACPI Power-Management Register Window

This block holds the fixed power-management registers of a south bridge behind a 64-byte I/O window. Software reaches three 16-bit registers through it: an event status register, an event enable register and a control register. It can also read a free-running power-management timer as a 32-bit word. The window's base address comes from a configuration word. A decode-enable bit in a second configuration byte switches the whole window on or off.

Four hardware events can set status bits: timer overflow, global lock, power button and real-time clock. Software clears a status bit by writing a one to it. A level-sensitive system control interrupt (`sci`) stays high while any of those four status bits is set together with its enable bit. The timer counts up by one for each `tick` pulse, which is nominally 3.579545 MHz. A change of its most significant bit raises the overflow status bit. The sleep sequencing that the control register would normally start lies outside this block. The control register is only storage here.

Top module: `acpi_pm_regs`

## Requirements
- R1: After reset the status, enable and control registers read 0x0000, the timer reads 0 and `sci` is low.
- R2: An access hits the window only when `cfg_ctrl[0]` is 1 and `io_addr[15:6]` equals `cfg_base[15:6]`, so the low six base bits and `cfg_base[31:16]` are ignored. A miss returns 0 on `io_rdata` and changes no register.
- R3: A 16-bit access (`io_wide`=0) selects its register by `io_addr[3:0]`: 0x0 is status, 0x2 is enable and 0x4 is control. Any other offset reads 0 and ignores writes. Offsets 0x10 and above inside the window alias the same registers.
- R4: A 32-bit read (`io_wide`=1) at offset 0x8 returns the timer zero-extended to 32 bits. Any other 32-bit read returns 0, and every 32-bit write is ignored.
- R5: The event inputs set status bits: `evt_gbl` sets bit 5, `evt_pwrbtn` sets bit 8 and `evt_rtc` sets bit 10. A 16-bit status write clears each bit that has a 1 in `io_wdata[15:0]` and leaves the other bits unchanged. An event and a clear in the same cycle leave the bit set.
- R6: Each cycle with `tick` high advances the timer by one, modulo 2^TMR_W. The timer holds its value otherwise.
- R7: Status bit 0 is set in the cycle when a tick changes the timer's most significant bit. This happens on the rise from 2^(TMR_W-1)-1 and on the wrap to 0.
- R8: `sci` is high exactly when (status AND enable) has bit 0, 5, 8 or 10 set. Enable bits outside these four have no effect. `sci` follows a status or enable write in the cycle after the write edge.
- R9: `io_rdata` is combinational and valid in the same cycle as `io_rd`. It is 0 whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 32 | Configuration word holding the window base address |
| cfg_ctrl | input | 8 | Configuration byte; bit 0 enables window decode |
| io_addr | input | 16 | I/O address |
| io_wide | input | 1 | Access size: 0 = 16-bit, 1 = 32-bit |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data |
| tick | input | 1 | Timer advance enable |
| evt_gbl | input | 1 | Global-lock event pulse |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_rtc | input | 1 | Real-time-clock event pulse |
| sci | output | 1 | System control interrupt, level |

## Verification
The bench builds the block with TMR_W = 6, so the timer's top bit changes after 32 ticks instead of 2^23. This puts both overflow points within a short run: the rise of the top bit and the wrap to zero. The bench also checks the exact timer value on each side of those points. The base word carries nonzero low bits and upper half-word bits, so the address masking is exercised on every access.

// File: rtl/acpi_pm_regs.sv
`timescale 1ns/1ps
module acpi_pm_regs #(
  parameter int          TMR_W    = 24,
  parameter int          WIN_BITS = 6,
  parameter logic [15:0] SCI_MASK = 16'h0521
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_base,
  input  logic [7:0]  cfg_ctrl,
  input  logic [15:0] io_addr,
  input  logic        io_wide,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  input  logic        tick,
  input  logic        evt_gbl,
  input  logic        evt_pwrbtn,
  input  logic        evt_rtc,
  output logic        sci
);

  localparam logic [3:0] OFS_STS = 4'h0;
  localparam logic [3:0] OFS_EN  = 4'h2;
  localparam logic [3:0] OFS_CTL = 4'h4;
  localparam logic [3:0] OFS_TMR = 4'h8;

  logic [15:0]      sts_q, en_q, ctl_q;
  logic [TMR_W-1:0] cnt_q, cnt_nxt;
  logic             hit, wr16, ovf;
  logic [3:0]       sel;
  logic [15:0]      set_bits, clr_bits;

  assign hit  = cfg_ctrl[0] && (io_addr[15:WIN_BITS] == cfg_base[15:WIN_BITS]);
  assign sel  = io_addr[3:0];
  assign wr16 = io_wr && hit && !io_wide;

  assign cnt_nxt = cnt_q + TMR_W'(1);
  assign ovf     = tick && (cnt_nxt[TMR_W-1] != cnt_q[TMR_W-1]);

  always_comb begin
    set_bits     = '0;
    set_bits[0]  = ovf;
    set_bits[5]  = evt_gbl;
    set_bits[8]  = evt_pwrbtn;
    set_bits[10] = evt_rtc;
  end

  assign clr_bits = (wr16 && sel == OFS_STS) ? io_wdata[15:0] : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_bits) | set_bits;
      if (wr16 && sel == OFS_EN)  en_q  <= io_wdata[15:0];
      if (wr16 && sel == OFS_CTL) ctl_q <= io_wdata[15:0];
      if (tick) cnt_q <= cnt_nxt;
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd && hit) begin
      if (!io_wide) begin
        case (sel)
          OFS_STS: io_rdata = {16'h0000, sts_q};
          OFS_EN:  io_rdata = {16'h0000, en_q};
          OFS_CTL: io_rdata = {16'h0000, ctl_q};
          default: io_rdata = '0;
        endcase
      end else if (sel == OFS_TMR) begin
        io_rdata = 32'(cnt_q);
      end
    end
  end

  assign sci = |(sts_q & en_q & SCI_MASK);

  logic unused_bits;
  assign unused_bits = ^{cfg_base[31:16], cfg_base[WIN_BITS-1:0], cfg_ctrl[7:1],
                         io_addr[WIN_BITS-1:4], io_wdata[31:16]};

endmodule

// File: rtl/acpi_pm_regs_chk.sv
`timescale 1ns/1ps
module acpi_pm_regs_chk #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_ctrl,
  input logic             io_rd,
  input logic             io_wr,
  input logic             io_wide,
  input logic [31:0]      io_rdata,
  input logic             tick,
  input logic             evt_pwrbtn,
  input logic             sci,
  input logic [15:0]      sts_q,
  input logic [15:0]      en_q,
  input logic [15:0]      ctl_q,
  input logic [TMR_W-1:0] cnt_q
);

  a_r2_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctrl[0] |-> io_rdata == 32'h0);

  a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 32'h0);

  a_r4_wide_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_wide) |=> ($stable(en_q) && $stable(ctl_q)));

  a_r5_pwrbtn_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pwrbtn |=> sts_q[8]);

  a_r6_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + TMR_W'(1));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  a_r7_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q[TMR_W-2:0] == '1) |=> sts_q[0]);

  a_r8_sci_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 16'h0) |-> !sci);

endmodule

bind acpi_pm_regs acpi_pm_regs_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .io_rd(io_rd), .io_wr(io_wr),
  .io_wide(io_wide), .io_rdata(io_rdata), .tick(tick), .evt_pwrbtn(evt_pwrbtn),
  .sci(sci), .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q), .cnt_q(cnt_q)
);

// File: tb/test_acpi_pm_regs.sv
`timescale 1ns/1ps
module test_acpi_pm_regs;
  localparam int TMR_W = 6;
  localparam logic [15:0] BASE = 16'hA5C0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h1234_A5C7;
  logic [7:0]  cfg_ctrl = 8'h01;
  logic [15:0] io_addr = '0;
  logic        io_wide = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        tick = 1'b0, evt_gbl = 1'b0, evt_pwrbtn = 1'b0, evt_rtc = 1'b0;
  logic        sci;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  acpi_pm_regs #(.TMR_W(TMR_W)) i_acpi_pm_regs (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ctrl(cfg_ctrl),
    .io_addr(io_addr), .io_wide(io_wide), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .tick(tick), .evt_gbl(evt_gbl),
    .evt_pwrbtn(evt_pwrbtn), .evt_rtc(evt_rtc), .sci(sci)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic wide, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wide = wide; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic wide, output logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_wide = wide; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(BASE + 16'h0, 1'b0, v); check("R1 status after reset", v, 32'h0);
    rd(BASE + 16'h2, 1'b0, v); check("R1 enable after reset", v, 32'h0);
    rd(BASE + 16'h4, 1'b0, v); check("R1 control after reset", v, 32'h0);
    rd(BASE + 16'h8, 1'b1, v); check("R1 timer after reset", v, 32'h0);
    check("R1 sci after reset", {31'b0, sci}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(BASE + 16'h2, 1'b0, 32'hFFFF_1234);
    rd(BASE + 16'h2, 1'b0, v); check("R3 enable readback", v, 32'h1234);
    wr(BASE + 16'h4, 1'b0, 32'h0000_BEEF);
    rd(BASE + 16'h4, 1'b0, v); check("R3 control readback", v, 32'hBEEF);
    wr(BASE + 16'h6, 1'b0, 32'h0000_5555);
    rd(BASE + 16'h6, 1'b0, v); check("R3 unmapped offset reads 0", v, 32'h0);
    rd(BASE + 16'h2, 1'b0, v); check("R3 unmapped write leaves enable", v, 32'h1234);
    rd(BASE + 16'h4, 1'b0, v); check("R3 unmapped write leaves control", v, 32'hBEEF);
    wr(BASE + 16'h12, 1'b0, 32'h0000_00FF);
    rd(BASE + 16'h2, 1'b0, v); check("R3 alias at 0x12 writes enable", v, 32'h00FF);
    @(negedge clk); io_addr = BASE + 16'h2; io_wide = 1'b0; io_rd = 1'b0;
    #1 check("R9 rdata zero without read", io_rdata, 32'h0);
  endtask

  task automatic t_wide;
    logic [31:0] v;
    rd(BASE + 16'h2, 1'b1, v); check("R4 32-bit read at enable is 0", v, 32'h0);
    wr(BASE + 16'h2, 1'b1, 32'h0000_FFFF);
    rd(BASE + 16'h2, 1'b0, v); check("R4 32-bit write ignored", v, 32'h00FF);
    rd(BASE + 16'h8, 1'b0, v); check("R4 16-bit read at timer is 0", v, 32'h0);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(BASE + 16'h42, 1'b0, 32'h0000_0AAA);
    rd(BASE + 16'h42, 1'b0, v); check("R2 outside window reads 0", v, 32'h0);
    rd(BASE + 16'h2, 1'b0, v); check("R2 outside write ignored", v, 32'h00FF);
    cfg_ctrl = 8'hFE;
    wr(BASE + 16'h2, 1'b0, 32'h0000_0BBB);
    rd(BASE + 16'h2, 1'b0, v); check("R2 decode off reads 0", v, 32'h0);
    cfg_ctrl = 8'h01;
    rd(BASE + 16'h2, 1'b0, v); check("R2 decode off write ignored", v, 32'h00FF);
  endtask

  task automatic t_status;
    logic [31:0] v;
    wr(BASE + 16'h2, 1'b0, 32'h0);
    @(negedge clk); evt_pwrbtn = 1'b1; evt_rtc = 1'b1; evt_gbl = 1'b1;
    @(negedge clk); evt_pwrbtn = 1'b0; evt_rtc = 1'b0; evt_gbl = 1'b0;
    rd(BASE + 16'h0, 1'b0, v); check("R5 events set bits 5,8,10", v, 32'h0520);
    check("R8 sci low with enable 0", {31'b0, sci}, 32'h0);
    wr(BASE + 16'h0, 1'b0, 32'h0000_0100);
    rd(BASE + 16'h0, 1'b0, v); check("R5 write-one clears bit 8", v, 32'h0420);
    wr(BASE + 16'h0, 1'b0, 32'h0);
    rd(BASE + 16'h0, 1'b0, v); check("R5 write zero keeps bits", v, 32'h0420);
    @(negedge clk); io_addr = BASE; io_wide = 1'b0; io_wdata = 32'h0100; io_wr = 1'b1; evt_pwrbtn = 1'b1;
    @(negedge clk); io_wr = 1'b0; evt_pwrbtn = 1'b0;
    rd(BASE + 16'h0, 1'b0, v); check("R5 event wins over clear", v, 32'h0520);
  endtask

  task automatic t_sci;
    logic [31:0] v;
    wr(BASE + 16'h2, 1'b0, 32'h0000_FADE);
    check("R8 enable outside mask gives no sci", {31'b0, sci}, 32'h0);
    wr(BASE + 16'h2, 1'b0, 32'h0000_0100);
    check("R8 power button enabled raises sci", {31'b0, sci}, 32'h1);
    wr(BASE + 16'h0, 1'b0, 32'h0000_0100);
    check("R8 clearing status drops sci", {31'b0, sci}, 32'h0);
    wr(BASE + 16'h2, 1'b0, 32'h0000_0400);
    check("R8 rtc enabled raises sci", {31'b0, sci}, 32'h1);
    wr(BASE + 16'h0, 1'b0, 32'h0000_FFFF);
    rd(BASE + 16'h0, 1'b0, v); check("R5 clear all", v, 32'h0);
  endtask

  task automatic t_timer;
    logic [31:0] v;
    wr(BASE + 16'h2, 1'b0, 32'h0000_0001);
    ticks(31);
    rd(BASE + 16'h8, 1'b1, v); check("R6 timer after 31 ticks", v, 32'd31);
    rd(BASE + 16'h0, 1'b0, v); check("R7 no overflow before msb change", v, 32'h0);
    ticks(1);
    rd(BASE + 16'h8, 1'b1, v); check("R6 timer after 32 ticks", v, 32'd32);
    rd(BASE + 16'h0, 1'b0, v); check("R7 overflow on msb rise", v, 32'h0001);
    check("R8 timer status raises sci", {31'b0, sci}, 32'h1);
    wr(BASE + 16'h0, 1'b0, 32'h0000_0001);
    ticks(32);
    rd(BASE + 16'h8, 1'b1, v); check("R6 timer wraps to 0", v, 32'd0);
    rd(BASE + 16'h0, 1'b0, v); check("R7 overflow on wrap", v, 32'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_wide;
    t_decode;
    t_status;
    t_sci;
    t_timer;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule